// File: doc/BRIEF.md
# Mixed-Sign Fractional Multiplier

This block multiplies two 16-bit operands in a single clock cycle and presents the product on a registered 40-bit output, ready to add into a wide accumulator. Each operand carries its own signedness flag. A signed operand is widened to 17 bits by copying its top bit. An unsigned operand is widened with a zero. A single signed 17x17 core therefore covers signed, unsigned and mixed-sign products with no extra correction logic.

A mode flag selects integer or fractional interpretation. In fractional mode the product of two Q15 values is doubled to remove the duplicated sign bit, which gives a Q31 result. The one case that wraps in narrower designs is -1.0 times -1.0 (0x8000 by 0x8000, both signed). Here the 17-bit widening leaves room for it, so it comes out as the positive value 0x0080000000. The 40-bit output is the core result sign-extended, so the top bits always agree with the sign of the product.

The output register has a synchronous active-high reset. The product of the operands and flags presented before a rising clock edge appears on the output after that edge.

Top module: `mixsign_mul`

## Requirements
- R1: While `rst` is high at a rising edge, `prod_out` becomes 0 after that edge.
- R2: With both signed flags high and `frac_en` low, `prod_out` equals the two's-complement product of the operands, sign-extended to 40 bits.
- R3: With both signed flags low and `frac_en` low, `prod_out` equals the unsigned product, and bits 39:32 are zero.
- R4: With `a_is_signed` high and `b_is_signed` low, operand A is read as two's complement and operand B as unsigned. The reverse setting applies the reverse rule.
- R5: With `frac_en` high, `prod_out` equals twice the product that the same operands and flags give in integer mode, so bit 0 is zero.
- R6: With both operands 0x8000, both signed flags high and `frac_en` high, `prod_out` is 0x0080000000, a positive value.
- R7: Bits 39:33 of `prod_out` are always all equal, because the output is a sign extension of the product.
- R8: The output shows the product of the inputs sampled at the previous rising edge, with exactly one cycle of latency, and a new product is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| a_is_signed | input | 1 | 1: operand A is two's complement; 0: unsigned |
| b_is_signed | input | 1 | 1: operand B is two's complement; 0: unsigned |
| frac_en | input | 1 | 1: fractional Q15 x Q15 -> Q31; 0: integer |
| prod_out | output | 40 | Registered product, sign-extended |

## Verification
The operand space is too large to cover completely. The results most likely to go wrong depend on the top bits of both operands together with their flags, such as 0x8000 and 0xFFFF read as signed or as unsigned. The stimulus therefore crosses a set of corner operands (zero, one, the largest and smallest values, and values next to the sign boundary) against each other under all eight flag settings. It then adds a run of pseudo-random operand pairs, with flags drawn at random, issued back to back so that the one-cycle latency is checked under a new input every cycle.

// File: rtl/mixsign_mul_pkg.sv
package mixsign_mul_pkg;

    localparam int OPND_W = 16;
    localparam int ACC_W  = 40;

    typedef enum logic {
        MODE_INT  = 1'b0,
        MODE_FRAC = 1'b1
    } mul_mode_e;

    // Extension bit for one operand: its MSB when it is signed, zero otherwise
    function automatic logic ext_bit(input logic msb, input logic is_signed);
        return msb & is_signed;
    endfunction

endpackage

// File: rtl/mixsign_mul_ext.sv
module mixsign_mul_ext #(
    parameter int W = 16
) (
    input  logic [W-1:0]        din,
    input  logic                is_signed,
    output logic signed [W:0]   dext
);
    import mixsign_mul_pkg::*;

    always_comb begin
        dext = $signed({ext_bit(din[W-1], is_signed), din});
    end
endmodule

// File: rtl/mixsign_mul_core.sv
module mixsign_mul_core #(
    parameter int W = 16
) (
    input  logic signed [W:0]       a_ext,
    input  logic signed [W:0]       b_ext,
    output logic signed [2*W+1:0]   prod
);
    localparam int PW = 2 * (W + 1);

    logic signed [PW-1:0] a_wide;
    logic signed [PW-1:0] b_wide;

    always_comb begin
        a_wide = PW'(a_ext);
        b_wide = PW'(b_ext);
        prod   = a_wide * b_wide;
    end
endmodule

// File: rtl/mixsign_mul_scale.sv
module mixsign_mul_scale #(
    parameter int W  = 16,
    parameter int AW = 40
) (
    input  logic signed [2*W+1:0]   prod,
    input  mixsign_mul_pkg::mul_mode_e mode,
    output logic [AW-1:0]           scaled
);
    import mixsign_mul_pkg::*;

    logic signed [AW-1:0] wide;

    always_comb begin
        wide = AW'(prod);
        if (mode == MODE_FRAC) begin
            scaled = wide <<< 1;
        end else begin
            scaled = wide;
        end
    end
endmodule

// File: rtl/mixsign_mul.sv
module mixsign_mul #(
    parameter int W  = mixsign_mul_pkg::OPND_W,
    parameter int AW = mixsign_mul_pkg::ACC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    opnd_b,
    input  logic            a_is_signed,
    input  logic            b_is_signed,
    input  logic            frac_en,
    output logic [AW-1:0]   prod_out
);
    import mixsign_mul_pkg::*;

    localparam int EW = W + 1;
    localparam int PW = 2 * EW;
    localparam int NOPS = 2;

    logic [W-1:0]          opnd   [NOPS];
    logic                  sflag  [NOPS];
    logic signed [EW-1:0]  ext    [NOPS];
    logic signed [PW-1:0]  raw_prod;
    logic [AW-1:0]         scaled;
    mul_mode_e             mode;

    always_comb begin
        opnd[0]  = opnd_a;
        opnd[1]  = opnd_b;
        sflag[0] = a_is_signed;
        sflag[1] = b_is_signed;
        mode     = frac_en ? MODE_FRAC : MODE_INT;
    end

    for (genvar i = 0; i < NOPS; i++) begin : g_ext
        mixsign_mul_ext #(.W(W)) ext_i (
            .din       (opnd[i]),
            .is_signed (sflag[i]),
            .dext      (ext[i])
        );
    end

    mixsign_mul_core #(.W(W)) core_i (
        .a_ext (ext[0]),
        .b_ext (ext[1]),
        .prod  (raw_prod)
    );

    mixsign_mul_scale #(.W(W), .AW(AW)) scale_i (
        .prod   (raw_prod),
        .mode   (mode),
        .scaled (scaled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_out <= '0;
        end else begin
            prod_out <= scaled;
        end
    end
endmodule

// File: rtl/mixsign_mul_chk.sv
module mixsign_mul_chk #(
    parameter int W  = 16,
    parameter int AW = 40
) (
    input logic            clk,
    input logic            rst,
    input logic [W-1:0]    opnd_a,
    input logic [W-1:0]    opnd_b,
    input logic            a_is_signed,
    input logic            b_is_signed,
    input logic            frac_en,
    input logic [AW-1:0]   prod_out
);
    localparam int TOPB = 2 * W + 1;
    localparam int NTOP = AW - TOPB;
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic [AW-1:0] ONE_Q = AW'(1) << (2 * W - 1);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (prod_out == '0));

    // R3
    unsigned_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!a_is_signed && !b_is_signed && !frac_en) |=> (prod_out[AW-1:2*W] == '0));

    // R5
    frac_lsb_zero_chk: assert property (@(posedge clk) disable iff (rst)
        frac_en |=> (prod_out[0] == 1'b0));

    // R6
    neg_one_square_chk: assert property (@(posedge clk) disable iff (rst)
        (a_is_signed && b_is_signed && frac_en && opnd_a == MINV && opnd_b == MINV)
        |=> (prod_out == ONE_Q));

    // R7
    sign_ext_chk: assert property (@(posedge clk)
        ($countones(prod_out[AW-1:TOPB]) == 0) || ($countones(prod_out[AW-1:TOPB]) == NTOP));

    // R8
    zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
        ((opnd_a == '0) || (opnd_b == '0)) |=> (prod_out == '0));
endmodule

bind mixsign_mul mixsign_mul_chk #(.W(W), .AW(AW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .a_is_signed (a_is_signed),
    .b_is_signed (b_is_signed),
    .frac_en     (frac_en),
    .prod_out    (prod_out)
);

// File: tb/mixsign_mul_tb_top.sv
module mixsign_mul_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] opnd_a;
    logic [15:0] opnd_b;
    logic        a_is_signed;
    logic        b_is_signed;
    logic        frac_en;
    logic [39:0] prod_out;

    int n_vec  = 0;
    int n_fail = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    mixsign_mul dut_i (
        .clk         (clk),
        .rst         (rst),
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .a_is_signed (a_is_signed),
        .b_is_signed (b_is_signed),
        .frac_en     (frac_en),
        .prod_out    (prod_out)
    );

    logic [15:0] corners [12] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFE,
                                  16'h7FFF, 16'h8000, 16'h8001, 16'hFFFE,
                                  16'hFFFF, 16'h4000, 16'hC000, 16'h5A5A};

    function automatic logic [39:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic sa, input logic sb, input logic fr);
        longint ea, eb, p;
        ea = sa ? longint'($signed(a)) : longint'(a);
        eb = sb ? longint'($signed(b)) : longint'(b);
        p  = ea * eb;
        if (fr) p = p * 2;
        return p[39:0];
    endfunction

    function automatic string tag_of(input logic [15:0] a, input logic [15:0] b,
                                     input logic sa, input logic sb, input logic fr);
        if (fr && sa && sb && a == 16'h8000 && b == 16'h8000) return "R6";
        if (fr) return "R5";
        if (sa && sb) return "R2";
        if (!sa && !sb) return "R3";
        return "R4";
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Drive at a falling edge; result is checked at the following falling edge (R8)
    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic sa, input logic sb, input logic fr);
        logic [39:0] exp;
        opnd_a = a; opnd_b = b; a_is_signed = sa; b_is_signed = sb; frac_en = fr;
        exp = model(a, b, sa, sb, fr);
        @(negedge clk);
        n_vec++;
        if (prod_out !== exp) begin
            n_fail++;
            $display("FAIL %s/R8 a=%h b=%h sa=%0b sb=%0b fr=%0b got=%h exp=%h",
                     tag_of(a, b, sa, sb, fr), a, b, sa, sb, fr, prod_out, exp);
        end
        if (!(prod_out[39:33] == 7'h00 || prod_out[39:33] == 7'h7F)) begin
            n_fail++;
            $display("FAIL R7 top bits not a sign extension got=%h exp=sign-extended", prod_out);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired got=timeout exp=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        opnd_a = 16'hFFFF; opnd_b = 16'hFFFF;
        a_is_signed = 1'b0; b_is_signed = 1'b0; frac_en = 1'b1;
        repeat (3) @(negedge clk);
        n_vec++;
        if (prod_out !== 40'h0) begin
            n_fail++;
            $display("FAIL R1 reset got=%h exp=0000000000", prod_out);
        end
        rst = 1'b0;

        // Corner sweep under all flag settings (R2..R7)
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 12; i++) begin
                for (int j = 0; j < 12; j++) begin
                    apply(corners[i], corners[j], m[0], m[1], m[2]);
                end
            end
        end

        // Explicit -1.0 x -1.0 check (R6)
        apply(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1);
        n_vec++;
        if (prod_out !== 40'h00_8000_0000) begin
            n_fail++;
            $display("FAIL R6 got=%h exp=0080000000", prod_out);
        end

        // Back-to-back pseudo-random vectors (R8 throughput)
        for (int k = 0; k < 4000; k++) begin
            rng = next_rng(rng);
            apply(rng[15:0], rng[31:16], rng[3], rng[17], rng[29]);
        end

        // Reset in mid-stream clears the output (R1)
        opnd_a = 16'h7FFF; opnd_b = 16'h7FFF; a_is_signed = 1'b1; b_is_signed = 1'b1;
        frac_en = 1'b0; rst = 1'b1;
        @(negedge clk);
        n_vec++;
        if (prod_out !== 40'h0) begin
            n_fail++;
            $display("FAIL R1 mid-run reset got=%h exp=0000000000", prod_out);
        end
        rst = 1'b0;
        apply(16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule